// File: doc/BRIEF.md
# CRC-4 Multiframe Alignment Loss Controller

This block decides, frame by frame, whether the receive side of a 2.048 Mbit/s framer may trust its CRC-4 multiframe boundaries. It watches the basic frame alignment state, a strobe from an external pattern detector that fires whenever a multiframe alignment word is recognised, and a strobe that marks each frame boundary. From these it keeps a loss-of-multiframe-alignment status bit. It opens or closes the enables of every monitor that depends on CRC-4 framing: the CRC error counter, the errored-second and severely-errored-second monitor, the received E-bit monitor, the continuous E-bit monitor and the Sa6 code monitors. Two configuration bits let the block ask the transmitter to send A = 1 and E = 0 while alignment is missing.

The control is a five-state machine:
- `ST_LOST_BFA`: basic frame alignment is absent. It is the reset state and is entered from any state when `bfa_ok` is low.
- `ST_HUNT`: waiting for a first alignment word.
- `ST_CONFIRM`: a first word has been seen, and the block is waiting for a second one exactly `GAP_FRAMES` frames later.
- `ST_ARMED`: alignment has been declared, and the block is waiting for the next frame boundary.
- `ST_ALIGNED`: alignment is held.

The transitions are:
- LOST_BFA to HUNT when `bfa_ok` returns.
- HUNT to CONFIRM on a hit.
- CONFIRM to ARMED on a hit at the right spacing.
- CONFIRM to CONFIRM on a hit at the wrong spacing, which re-arms the search.
- HUNT or CONFIRM to HUNT when the search window of `WIN_FRAMES` frames expires.
- ARMED to ALIGNED on a frame tick.
- Any state to LOST_BFA when `bfa_ok` is low.

The pattern detector and the monitors themselves sit outside this block.

Top module: `mfa_loss_ctrl`

## Requirements
- R1: While reset is held, and directly after it, the block reports loss: `lomf` is 1 and all five monitor enables are 0.
- R2: When `bfa_ok` is 0, `lomf` is 1 in that same cycle, combinationally and from any state, including aligned. The state then returns to LOST_BFA at the next clock edge.
- R3: While `bfa_ok` is 0, hits and frame ticks have no effect. A search starts only in the cycle after `bfa_ok` returns, with a fresh window and no remembered first hit.
- R4: The five monitor enables (`en_crc_cnt`, `en_es_ses`, `en_ebit_rx`, `en_ebit_cont`, `en_sa6`) are always equal to each other and equal to the inverse of `lomf`.
- R5: `tx_a_force1` equals `cfg_force_a` AND `lomf`.
- R6: `tx_e_force0` equals `cfg_force_e` AND `lomf`.
- R7: Alignment is declared when a hit arrives with exactly `GAP_FRAMES` (16) frame ticks counted since the previous accepted hit. Ticks in the hit cycles themselves are not counted. A hit at any other spacing becomes the new first hit.
- R8: The search window counts frame ticks from the start of the search. If `WIN_FRAMES` (64) ticks pass without a declaration, the search restarts on the 64th tick and drops any pending first hit. `lomf` stays 1 throughout.
- R9: After a declaration, `lomf` clears, the enables rise and both transmit overrides release together. This happens at the clock edge of the next frame tick and never earlier.
- R10: In the aligned state, hits and ticks have no effect. Only a drop of `bfa_ok` leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bfa_ok | input | 1 | Basic frame alignment currently held |
| mfas_hit | input | 1 | One-cycle strobe: multiframe alignment word detected |
| frm_tick | input | 1 | One-cycle strobe at each frame boundary |
| cfg_force_a | input | 1 | Request A = 1 on transmit during loss |
| cfg_force_e | input | 1 | Request E = 0 on transmit during loss |
| lomf | output | 1 | Loss-of-multiframe-alignment status |
| en_crc_cnt | output | 1 | CRC-4 error counter enable |
| en_es_ses | output | 1 | Errored / severely errored second monitor enable |
| en_ebit_rx | output | 1 | Received E-bit monitor enable |
| en_ebit_cont | output | 1 | Continuous E-bit monitor enable |
| en_sa6 | output | 1 | Sa6 code monitoring and counting enable |
| tx_a_force1 | output | 1 | Override request: transmit A = 1 |
| tx_e_force0 | output | 1 | Override request: transmit E = 0 |

## Verification
A drop of `bfa_ok` shows on every output in the same cycle with no clock edge. The bench checks this one nanosecond after changing the input, without clocking. All other results follow one register stage: a hit or tick sampled at an edge changes the state at that edge. The bench drives each stimulus one nanosecond after a rising edge and reads the outputs one nanosecond after the next edge. The declaration case is read twice: once after the accepting hit, where loss must still be shown, and once after the following tick, where alignment must appear.

// File: rtl/mfa_pkg.sv
package mfa_pkg;

    typedef enum logic [2:0] {
        ST_LOST_BFA = 3'd0,
        ST_HUNT     = 3'd1,
        ST_CONFIRM  = 3'd2,
        ST_ARMED    = 3'd3,
        ST_ALIGNED  = 3'd4
    } mfa_state_e;

    // Number of CRC-4 dependent monitors gated by the block
    localparam int unsigned NUM_MON_EN = 5;

endpackage

// File: rtl/mfa_frame_timer.sv
module mfa_frame_timer #(
    parameter int unsigned GAP_FRAMES = 16,
    parameter int unsigned WIN_FRAMES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_tick,
    input  logic gap_clr,
    input  logic win_clr,
    output logic gap_match,
    output logic win_expire
);

    localparam int unsigned GW = $clog2(GAP_FRAMES + 2);
    localparam int unsigned WW = $clog2(WIN_FRAMES + 1);
    localparam logic [GW-1:0] GAP_HIT  = GW'(GAP_FRAMES);
    localparam logic [GW-1:0] GAP_LIM  = GW'(GAP_FRAMES + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_FRAMES - 1);

    logic [GW-1:0] gap_cnt;
    logic [WW-1:0] win_cnt;

    // Frames since the last accepted hit, saturating one past the target
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (gap_clr) begin
            gap_cnt <= '0;
        end else if (frm_tick && gap_cnt != GAP_LIM) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // Frames since the search window opened
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (win_clr) begin
            win_cnt <= '0;
        end else if (frm_tick && win_cnt != WIN_LAST) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    always_comb begin
        gap_match  = (gap_cnt == GAP_HIT);
        win_expire = frm_tick && (win_cnt == WIN_LAST);
    end

    AST_GAP_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gap_match) |-> $past(frm_tick)); // R7

    AST_GAP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_cnt == GAP_LIM && !gap_clr) |=> gap_cnt == GAP_LIM); // R7

    AST_WIN_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt == WIN_LAST && !win_clr) |=> win_cnt == WIN_LAST); // R8

endmodule

// File: rtl/mfa_search_fsm.sv
module mfa_search_fsm
    import mfa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bfa_ok,
    input  logic       mfas_hit,
    input  logic       frm_tick,
    input  logic       gap_match,
    input  logic       win_expire,
    output mfa_state_e state_q,
    output logic       gap_clr,
    output logic       win_clr
);

    mfa_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOST_BFA;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!bfa_ok) begin
            state_d = ST_LOST_BFA;
        end else begin
            unique case (state_q)
                ST_LOST_BFA: state_d = ST_HUNT;
                ST_HUNT: begin
                    if (win_expire)    state_d = ST_HUNT;
                    else if (mfas_hit) state_d = ST_CONFIRM;
                end
                ST_CONFIRM: begin
                    if (mfas_hit && gap_match) state_d = ST_ARMED;
                    else if (win_expire)       state_d = ST_HUNT;
                    else if (mfas_hit)         state_d = ST_CONFIRM;
                end
                ST_ARMED: begin
                    if (frm_tick) state_d = ST_ALIGNED;
                end
                ST_ALIGNED: state_d = ST_ALIGNED;
                default:    state_d = ST_LOST_BFA;
            endcase
        end
    end

    // Counter control: window only runs while searching, gap only while confirming
    always_comb begin
        win_clr = !bfa_ok || win_expire ||
                  !(state_q == ST_HUNT || state_q == ST_CONFIRM);
        gap_clr = (state_q != ST_CONFIRM) || mfas_hit || win_expire;
    end

    AST_BFA_DROP_TO_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        !bfa_ok |=> state_q == ST_LOST_BFA); // R2

    AST_SEARCH_NEEDS_BFA: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_LOST_BFA && state_q != ST_LOST_BFA) |-> $past(bfa_ok)); // R3

    AST_ARMED_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && $past(state_q) != ST_ARMED) |-> $past(mfas_hit)); // R7

    AST_ALIGN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALIGNED && $past(state_q) != ST_ALIGNED)
            |-> ($past(frm_tick) && $past(state_q) == ST_ARMED)); // R9

    AST_ALIGNED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ALIGNED && $past(bfa_ok)) |-> state_q == ST_ALIGNED); // R10

endmodule

// File: rtl/mfa_resp_gen.sv
module mfa_resp_gen
    import mfa_pkg::*;
(
    input  logic                  bfa_ok,
    input  mfa_state_e            state_q,
    input  logic                  cfg_force_a,
    input  logic                  cfg_force_e,
    output logic                  lomf,
    output logic [NUM_MON_EN-1:0] mon_en,
    output logic                  tx_a_force1,
    output logic                  tx_e_force0
);

    logic held;

    always_comb begin
        held        = bfa_ok && (state_q == ST_ALIGNED);
        lomf        = !held;
        tx_a_force1 = cfg_force_a && !held;
        tx_e_force0 = cfg_force_e && !held;
    end

    for (genvar gi = 0; gi < int'(NUM_MON_EN); gi++) begin : g_mon
        assign mon_en[gi] = held;
    end

endmodule

// File: rtl/mfa_loss_ctrl.sv
module mfa_loss_ctrl
    import mfa_pkg::*;
#(
    parameter int unsigned GAP_FRAMES = 16,
    parameter int unsigned WIN_FRAMES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bfa_ok,
    input  logic mfas_hit,
    input  logic frm_tick,
    input  logic cfg_force_a,
    input  logic cfg_force_e,
    output logic lomf,
    output logic en_crc_cnt,
    output logic en_es_ses,
    output logic en_ebit_rx,
    output logic en_ebit_cont,
    output logic en_sa6,
    output logic tx_a_force1,
    output logic tx_e_force0
);

    mfa_state_e            state_q;
    logic                  gap_clr;
    logic                  win_clr;
    logic                  gap_match;
    logic                  win_expire;
    logic [NUM_MON_EN-1:0] mon_en;

    mfa_frame_timer #(
        .GAP_FRAMES (GAP_FRAMES),
        .WIN_FRAMES (WIN_FRAMES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_tick   (frm_tick),
        .gap_clr    (gap_clr),
        .win_clr    (win_clr),
        .gap_match  (gap_match),
        .win_expire (win_expire)
    );

    mfa_search_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bfa_ok     (bfa_ok),
        .mfas_hit   (mfas_hit),
        .frm_tick   (frm_tick),
        .gap_match  (gap_match),
        .win_expire (win_expire),
        .state_q    (state_q),
        .gap_clr    (gap_clr),
        .win_clr    (win_clr)
    );

    mfa_resp_gen u_resp (
        .bfa_ok      (bfa_ok),
        .state_q     (state_q),
        .cfg_force_a (cfg_force_a),
        .cfg_force_e (cfg_force_e),
        .lomf        (lomf),
        .mon_en      (mon_en),
        .tx_a_force1 (tx_a_force1),
        .tx_e_force0 (tx_e_force0)
    );

    assign en_crc_cnt   = mon_en[0];
    assign en_es_ses    = mon_en[1];
    assign en_ebit_rx   = mon_en[2];
    assign en_ebit_cont = mon_en[3];
    assign en_sa6       = mon_en[4];

    AST_ENABLES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mon_en) == 0) || ($countones(mon_en) == int'(NUM_MON_EN))); // R4

    AST_EN_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_crc_cnt) |-> $past(frm_tick)); // R9

    AST_TXA_RELEASE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_a_force1) && cfg_force_a && $past(cfg_force_a)) |-> en_sa6); // R5

    AST_TXE_RELEASE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_e_force0) && cfg_force_e && $past(cfg_force_e)) |-> en_ebit_rx); // R6

    AST_LOSS_ON_BFA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bfa_ok) |-> (lomf && !en_crc_cnt)); // R2

endmodule

// File: tb/mfa_loss_ctrl_tb.sv
module mfa_loss_ctrl_tb;

    localparam int GAP = 16;
    localparam int WIN = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, bfa_ok, mfas_hit, frm_tick, cfg_force_a, cfg_force_e;
    logic lomf, en_crc_cnt, en_es_ses, en_ebit_rx, en_ebit_cont, en_sa6;
    logic tx_a_force1, tx_e_force0;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    mfa_loss_ctrl #(.GAP_FRAMES(GAP), .WIN_FRAMES(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .bfa_ok(bfa_ok), .mfas_hit(mfas_hit),
        .frm_tick(frm_tick), .cfg_force_a(cfg_force_a), .cfg_force_e(cfg_force_e),
        .lomf(lomf), .en_crc_cnt(en_crc_cnt), .en_es_ses(en_es_ses),
        .en_ebit_rx(en_ebit_rx), .en_ebit_cont(en_ebit_cont), .en_sa6(en_sa6),
        .tx_a_force1(tx_a_force1), .tx_e_force0(tx_e_force0)
    );

    wire [7:0] outs = {lomf, en_crc_cnt, en_es_ses, en_ebit_rx, en_ebit_cont,
                       en_sa6, tx_a_force1, tx_e_force0};

    // Expected output vector from R4, R5, R6
    function automatic logic [7:0] expv(bit lost, bit a, bit e);
        return {lost, {5{~lost}}, a & lost, e & lost};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic cyc(bit t, bit h);
        frm_tick = t;
        mfas_hit = h;
        @(posedge clk);
        #1;
        frm_tick = 1'b0;
        mfas_hit = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
    endtask

    task automatic restart_search();
        bfa_ok = 1'b0;
        cyc(1'b0, 1'b0);
        bfa_ok = 1'b1;
        cyc(1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bfa_ok = 1'b0; mfas_hit = 1'b0; frm_tick = 1'b0;
        cfg_force_a = 1'b0; cfg_force_e = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", outs, expv(1, 0, 0));
        bfa_ok = 1'b1; cfg_force_a = 1'b1;
        cyc(1'b1, 1'b1);
        chk("R1 reset held", outs, expv(1, 1, 0));
        rst_n = 1'b1;
        cyc(1'b0, 1'b0);
        chk("R1 after reset", outs, expv(1, 1, 0));

        // R7 R9 R10 R2 R5 R6: spacing sweep under every override configuration
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int g = 0; g <= 20; g++) begin
                bit a, e, lk;
                a = cfg[0]; e = cfg[1]; lk = (g == GAP);
                cfg_force_a = a; cfg_force_e = e;
                restart_search();
                cyc(1'b0, 1'b1);
                ticks(g);
                cyc(1'b0, 1'b1);
                chk("R9 no early release", outs, expv(1, a, e));
                cyc(1'b1, 1'b0);
                chk("R7 spacing", outs, expv(!lk, a, e));
                if (!lk) begin
                    ticks(GAP - 1);
                    cyc(1'b0, 1'b1);
                    cyc(1'b1, 1'b0);
                    chk("R7 rearm", outs, expv(0, a, e));
                end
                cyc(1'b0, 1'b1);
                cyc(1'b1, 1'b0);
                chk("R10 aligned ignores hits", outs, expv(0, a, e));
                bfa_ok = 1'b0;
                #1;
                chk("R2 same cycle", outs, expv(1, a, e));
                cyc(1'b0, 1'b0);
                bfa_ok = 1'b1;
                #1;
                chk("R2 state returned to loss", outs, expv(1, a, e));
            end
        end

        cfg_force_a = 1'b1; cfg_force_e = 1'b1;

        // R3: stimulus during loss of basic alignment is ignored
        bfa_ok = 1'b0;
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        ticks(GAP);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        chk("R3 ignored while lost", outs, expv(1, 1, 1));
        bfa_ok = 1'b1;
        cyc(1'b1, 1'b1);
        chk("R3 no carry into hunt", outs, expv(1, 1, 1));
        cyc(1'b0, 1'b1);
        ticks(GAP);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        chk("R3 search after regain", outs, expv(0, 1, 1));

        // R3: a drop mid-confirm discards the first hit
        restart_search();
        cyc(1'b0, 1'b1);
        ticks(8);
        bfa_ok = 1'b0;
        cyc(1'b1, 1'b0);
        bfa_ok = 1'b1;
        cyc(1'b0, 1'b0);
        ticks(7);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        chk("R3 first hit discarded", outs, expv(1, 1, 1));

        // R8: window boundary sweep
        for (int pre = 40; pre <= 52; pre++) begin
            bit lk;
            lk = (pre + GAP < WIN);
            restart_search();
            ticks(pre);
            cyc(1'b0, 1'b1);
            ticks(GAP);
            cyc(1'b0, 1'b1);
            cyc(1'b1, 1'b0);
            chk("R8 window", outs, expv(!lk, 1, 1));
            if (!lk) begin
                ticks(GAP - 1);
                cyc(1'b0, 1'b1);
                cyc(1'b1, 1'b0);
                chk("R8 restarted search", outs, expv(0, 1, 1));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule